// File: doc/BRIEF.md
# Dual Timer Register Wrapper

This block places two identical down-counting timer channels behind one 4 KB register window. A bus master reads and writes 32-bit words by word address. The wrapper picks a channel from the address, passes that channel a local word offset starting at zero, and merges the two channel interrupts onto a single line. It also returns a fixed table of identification bytes near the top of the window. Every other location reads as zero and ignores writes. This includes the two integration test words, which are not implemented.

Each channel has its own tick-enable input, so the two can count at different rates from the same clock. A channel counts one step per tick while it runs. When it reaches its terminal step it raises its interrupt and reloads from its load value. Software clears the interrupt by writing the clear word.

Top module: `dual_timer_wrap`

## Requirements
- R1: Byte offsets 0x000 to 0x01F (word addresses 0 to 7) reach channel 0, which sees local word offset `waddr[4:2]`.
- R2: Byte offsets 0x020 to 0x03F (word addresses 8 to 15) reach channel 1, rebased by subtracting 0x20, so channel 1 also sees local word offset `waddr[4:2]`.
- R3: Byte offsets 0xFE0 to 0xFFC read one identification byte per word, zero-extended to 32 bits. In address order the bytes are 0x04, 0x18, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R4: The identification words are read-only. Writes to them leave their read values unchanged and change no channel state.
- R5: The integration test words at 0xF00 and 0xF04, and every other offset outside the two channel windows and the identification table, read as 0. Writes to them have no effect.
- R6: `irq` is the OR of the two channel interrupts. Each channel interrupt is its raw flag ANDed with its interrupt-enable bit.
- R7: A read accepted at a clock edge (`sel`=1, `wr`=0) presents its data on `rdata` after that edge. `rdata` holds its value while no read is accepted.
- R8: A channel counts only on its own tick input (`tick0` for channel 0, `tick1` for channel 1). A tick on one channel leaves the other channel's count unchanged.
- R9: Channel local map by word offset: 0 is the load value (read/write; a write also loads the count); 1 is the current count (read-only); 2 is control, with bit0 = run and bit1 = interrupt enable, and reads back 0x2 after reset; 3 clears the raw flag on write and reads 0; 4 is the raw flag; 5 is the masked flag; 6 and 7 read 0.
- R10: Each tick on a running channel decrements the count. A tick at count 1 sets the raw flag and reloads the count from the load value. A count of 0 holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Access request this cycle |
| wr | input | 1 | 1 = write, 0 = read |
| waddr | input | 10 | Word address (byte offset bits 11:2) |
| wdata | input | 32 | Write data |
| tick0 | input | 1 | Count enable for channel 0 |
| tick1 | input | 1 | Count enable for channel 1 |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Merged interrupt |

## Verification
The hardest case to reach from the ports is showing that a write to an unmapped or identification address changed nothing at all. Those locations always read as zero or as a constant, so a stray write into a channel would only show up in the channel's own registers. The bench first gives both channels distinct load values and control settings. It then writes to every word outside the channel windows and sweeps all 1024 word addresses again, comparing each one against a model that the bench computes. Separate tick sequences on each channel, with the interrupt enable both on and off, confirm the interrupt merge and that each channel counts only on its own tick.

// File: rtl/dual_timer_wrap.sv
module dual_timer_chan (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [2:0]  off,
  input  logic [31:0] wdata,
  input  logic        tick,
  output logic [31:0] rdata,
  output logic        irq
);
  logic [31:0] load, cnt;
  logic        run, ie, flag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load <= '0;
      cnt  <= '0;
      run  <= 1'b0;
      ie   <= 1'b1;
      flag <= 1'b0;
    end else begin
      if (tick && run && cnt != 32'd0) begin
        if (cnt == 32'd1) begin
          flag <= 1'b1;
          cnt  <= load;
        end else begin
          cnt <= cnt - 32'd1;
        end
      end
      if (we) begin
        case (off)
          3'd0: begin load <= wdata; cnt <= wdata; end
          3'd2: begin run <= wdata[0]; ie <= wdata[1]; end
          3'd3: flag <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (off)
      3'd0:    rdata = load;
      3'd1:    rdata = cnt;
      3'd2:    rdata = {30'd0, ie, run};
      3'd4:    rdata = {31'd0, flag};
      3'd5:    rdata = {31'd0, flag & ie};
      default: rdata = '0;
    endcase
  end

  assign irq = flag & ie;
endmodule

module dual_timer_wrap (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sel,
  input  logic        wr,
  input  logic [11:2] waddr,
  input  logic [31:0] wdata,
  input  logic        tick0,
  input  logic        tick1,
  output logic [31:0] rdata,
  output logic        irq
);
  logic        hit0, hit1, hit_id;
  logic [31:0] rd0, rd1, rd_mux;
  logic        irq0, irq1;
  logic [7:0]  id_byte;

  assign hit0   = (waddr[11:5] == 7'h00);
  assign hit1   = (waddr[11:5] == 7'h01);
  assign hit_id = (waddr[11:5] == 7'h7F);

  dual_timer_chan u_ch0 (
    .clk(clk), .rst_n(rst_n), .we(sel & wr & hit0), .off(waddr[4:2]),
    .wdata(wdata), .tick(tick0), .rdata(rd0), .irq(irq0)
  );

  dual_timer_chan u_ch1 (
    .clk(clk), .rst_n(rst_n), .we(sel & wr & hit1), .off(waddr[4:2]),
    .wdata(wdata), .tick(tick1), .rdata(rd1), .irq(irq1)
  );

  always_comb begin
    case (waddr[4:2])
      3'd0: id_byte = 8'h04;
      3'd1: id_byte = 8'h18;
      3'd2: id_byte = 8'h14;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  end

  assign rd_mux = hit0   ? rd0 :
                  hit1   ? rd1 :
                  hit_id ? {24'd0, id_byte} : 32'd0;

  always_ff @(posedge clk) begin
    if (!rst_n)          rdata <= '0;
    else if (sel && !wr) rdata <= rd_mux;
  end

  assign irq = irq0 | irq1;
endmodule

module dual_timer_wrap_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sel,
  input logic        wr,
  input logic [11:2] waddr,
  input logic        tick0,
  input logic        tick1,
  input logic [31:0] rdata,
  input logic        irq
);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && !wr) |=> $stable(rdata));

  p_id_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !wr && waddr[11:5] == 7'h7F) |=> rdata[31:8] == 24'd0);

  p_test_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !wr && waddr[11:3] == 9'h1E0) |=> rdata == 32'd0);

  p_irq_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(sel && wr));

  p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(tick0 || tick1 || (sel && wr)));
endmodule

bind dual_timer_wrap dual_timer_wrap_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .waddr(waddr),
  .tick0(tick0), .tick1(tick1), .rdata(rdata), .irq(irq)
);

// File: tb/dual_timer_wrap_tb.sv
module dual_timer_wrap_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [11:2] waddr = '0;
  logic [31:0] wdata = '0;
  logic        tick0 = 1'b0, tick1 = 1'b0;
  logic [31:0] rdata;
  logic        irq;

  int tests = 0, fails = 0;
  logic [31:0] m_load [2];
  logic [31:0] m_cnt  [2];
  logic [1:0]  m_ctrl [2];
  logic        m_flag [2];

  always #4 clk = ~clk;

  dual_timer_wrap u_dut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .waddr(waddr),
    .wdata(wdata), .tick0(tick0), .tick1(tick1), .rdata(rdata), .irq(irq)
  );

  function automatic logic [31:0] id_of(int i);
    case (i)
      0: return 32'h04; 1: return 32'h18; 2: return 32'h14; 3: return 32'h00;
      4: return 32'h0D; 5: return 32'hF0; 6: return 32'h05; default: return 32'hB1;
    endcase
  endfunction

  function automatic logic [31:0] expect_rd(int w);
    int c;
    int o;
    o = w % 8;
    if (w < 16) begin
      c = w / 8;
      case (o)
        0: return m_load[c];
        1: return m_cnt[c];
        2: return {30'd0, m_ctrl[c]};
        4: return {31'd0, m_flag[c]};
        5: return {31'd0, m_flag[c] & m_ctrl[c][1]};
        default: return 32'd0;
      endcase
    end
    if (w >= 1016) return id_of(w - 1016);
    return 32'd0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(int w, logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; waddr = w[9:0]; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic do_read(int w, output logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b0; waddr = w[9:0];
    @(negedge clk);
    sel = 1'b0;
    d = rdata;
  endtask

  task automatic tick(int c);
    @(negedge clk);
    if (c == 0) tick0 = 1'b1; else tick1 = 1'b1;
    @(negedge clk);
    tick0 = 1'b0; tick1 = 1'b0;
    if (m_ctrl[c][0] && m_cnt[c] != 0) begin
      if (m_cnt[c] == 1) begin m_flag[c] = 1'b1; m_cnt[c] = m_load[c]; end
      else m_cnt[c] = m_cnt[c] - 1;
    end
  endtask

  task automatic sweep(string req);
    logic [31:0] d;
    for (int w = 0; w < 1024; w++) begin
      do_read(w, d);
      check(req, d, expect_rd(w));
    end
  endtask

  task automatic set_ctrl(int c, logic [1:0] v);
    do_write(c * 8 + 2, {30'd0, v});
    m_ctrl[c] = v;
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] d, keep;
    for (int c = 0; c < 2; c++) begin
      m_load[c] = 0; m_cnt[c] = 0; m_ctrl[c] = 2'b10; m_flag[c] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    check("R9 reset irq", {31'd0, irq}, 32'd0);
    check("R7 reset rdata", rdata, 32'd0);
    sweep("R1 R2 R3 R5 R9 reset sweep");

    do_write(0, 32'h0000_0005); m_load[0] = 5; m_cnt[0] = 5;
    do_write(8, 32'hA5A5_0003); m_load[1] = 32'hA5A5_0003; m_cnt[1] = 32'hA5A5_0003;
    set_ctrl(0, 2'b11);
    set_ctrl(1, 2'b01);
    do_write(1, 32'hDEAD_BEEF);
    do_write(9, 32'h1234_5678);
    sweep("R1 R2 R9 after setup");

    for (int w = 16; w < 1024; w++) do_write(w, 32'hFFFF_FFFF);
    sweep("R4 R5 stray writes ignored");

    do_read(1017, d);
    keep = d;
    repeat (3) @(negedge clk);
    check("R7 rdata holds", rdata, keep);

    tick(0); tick(0);
    do_read(1, d);  check("R10 ch0 count", d, m_cnt[0]);
    do_read(9, d);  check("R8 ch1 untouched", d, m_cnt[1]);
    tick(1);
    do_read(9, d);  check("R8 ch1 count", d, m_cnt[1]);
    do_read(1, d);  check("R8 ch0 untouched", d, m_cnt[0]);

    tick(0); tick(0);
    check("R6 no irq yet", {31'd0, irq}, 32'd0);
    tick(0);
    check("R10 ch0 flag", {31'd0, irq}, 32'd1);
    do_read(1, d);  check("R10 ch0 reload", d, 32'd5);
    do_read(5, d);  check("R9 ch0 masked", d, 32'd1);

    do_write(3, 32'd0); m_flag[0] = 0;
    check("R9 clear irq", {31'd0, irq}, 32'd0);

    do_write(8, 32'd1); m_load[1] = 1; m_cnt[1] = 1;
    tick(1);
    do_read(12, d); check("R9 ch1 raw", d, 32'd1);
    check("R6 masked ch1", {31'd0, irq}, 32'd0);
    set_ctrl(1, 2'b11);
    check("R6 irq from ch1", {31'd0, irq}, 32'd1);
    do_read(13, d); check("R2 ch1 masked", d, 32'd1);

    do_write(0, 32'd0); m_load[0] = 0; m_cnt[0] = 0;
    tick(0);
    do_read(1, d);  check("R10 zero holds", d, 32'd0);

    sweep("R1 R2 R3 R9 final sweep");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule